// File: doc/BRIEF.md
# Parallel Port Mode Controller

This block is the processor-facing register file of a parallel I/O unit with three 8-bit ports (A, B, C), 24 lines in all. A 2-bit address, a chip select and one-cycle read and write strobes reach four locations: port A data at 0, port B data at 1, port C data at 2 and the control word at 3. The block holds the mode and direction of each port group and keeps the output latches. It sends direction and mode flags, plus interrupt-enable flags, to separate handshake channels. Those channels drive the port C lines that a handshake mode claims, and they return their status bits for port C reads.

A write to location 3 with bit 7 set is a mode-set word. It changes the configuration of both groups. A write to location 3 with bit 7 clear sets or clears one port C bit. While a port runs in strobed (mode 1) operation, a read of port C is a status word. It merges the handshake status bits, the interrupt-enable flags and the free general-purpose lines. The bidirectional encoding for group A is reserved: a mode-set word that carries it is dropped.

Top module: `pio_ctrl`

## Requirements
- R1: After reset every port is a mode 0 input, all latches and interrupt-enable flags are 0, no output enable is active, and a read of location 3 returns 9Bh.
- R2: Reads and writes take effect only when `cs` is high. The address selects port A (0), port B (1), port C (2) or the control word (3). Read data appears on `rdata` one clock after the read strobe.
- R3: A mode-set word (bit 7 = 1) sets the fields as follows: bits 6:5 are the group A mode, bit 4 = 1 makes port A an input, bit 3 = 1 makes PC7..PC4 inputs, bit 2 = 1 selects mode 1 for port B, bit 1 = 1 makes port B an input, and bit 0 = 1 makes PC3..PC0 inputs. Reading location 3 returns these fields with bit 7 set and bit 6 clear. For example, 90h gives an A mode 0 input and a B mode 0 output, and B0h gives an A mode 1 input.
- R4: Every accepted mode-set word clears the port A, B and C output latches and all interrupt-enable flags.
- R5: A mode-set word whose bit 6 is 1 (the bidirectional encoding) changes neither the configuration nor any latch.
- R6: A bit set/reset word (bit 7 = 0) writes bit 0 into the port C latch bit chosen by bits 3:1. It leaves every other latch bit and the configuration unchanged.
- R7: A port configured as output drives its latch on its output pins, asserts its output enables, and returns the latch when read. This holds in mode 0 and in mode 1.
- R8: A port or port C half configured as a mode 0 input returns the live input pins when read.
- R9: A port that is a mode 1 input captures its pins on its strobe input. A read returns the captured byte, not the live pins.
- R10: In mode 1, the port C lines claimed by a channel (A input: PC3, PC4, PC5; A output: PC3, PC6, PC7; B: PC0, PC1, PC2) read back as `hs_stat` bits. An exception is the interrupt-enable position, which reads back its flag. The remaining lines read as general-purpose lines.
- R11: A set/reset word on PC4 (A mode 1 input), PC6 (A mode 1 output) or PC2 (B mode 1) writes the matching interrupt-enable flag. That flag is shown on `inte_a` or `inte_b`. A flag outside its mode stays 0.
- R12: `pc_oe` is high only on port C lines that are not claimed by a handshake channel and whose half is configured as output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Location select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A latch out |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B latch out |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pins in |
| pc_out | output | 8 | Port C latch out |
| pc_oe | output | 8 | Port C per-line output enables |
| a_stb | input | 1 | Capture strobe from the port A channel |
| b_stb | input | 1 | Capture strobe from the port B channel |
| hs_stat | input | 8 | Status bits from the handshake channels, in port C positions |
| a_mode1 | output | 1 | Port A in strobed mode |
| a_is_in | output | 1 | Port A is an input |
| b_mode1 | output | 1 | Port B in strobed mode |
| b_is_in | output | 1 | Port B is an input |
| inte_a | output | 1 | Port A interrupt enable |
| inte_b | output | 1 | Port B interrupt enable |

## Verification
Some properties are checked on every cycle. The configuration outputs must not change without a control write. A mode-set word must clear the latches and enables. The bidirectional encoding must leave the configuration untouched. A set/reset word may change at most one port C bit. Claimed port C lines must never be driven, and an interrupt-enable flag may be set only in its mode.

Other behaviour shows only in the bench scenarios. These are the read multiplexing per mode, the strobe capture that hides later pin changes, and the merged status word with its enable positions. Each is checked against values worked out by hand.

// File: rtl/pio_ctrl.sv
module pio_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe,
  input  logic       a_stb,
  input  logic       b_stb,
  input  logic [7:0] hs_stat,
  output logic       a_mode1,
  output logic       a_is_in,
  output logic       b_mode1,
  output logic       b_is_in,
  output logic       inte_a,
  output logic       inte_b
);
  localparam logic [7:0] OWN_AI = 8'h38;
  localparam logic [7:0] OWN_AO = 8'hC8;
  localparam logic [7:0] OWN_B  = 8'h07;
  localparam logic [2:0] POS_AI = 3'd4;
  localparam logic [2:0] POS_AO = 3'd6;
  localparam logic [2:0] POS_B  = 3'd2;

  logic       a_m1, a_in, cu_in, b_m1, b_in, cl_in;
  logic [7:0] la, lb, lc, hold_a, hold_b;
  logic       ie_ai, ie_ao, ie_b;
  logic [7:0] own, dir_c, iem, iev, gp_c, rd_mux;
  logic       wr_ctl;

  assign wr_ctl = cs && wr && (addr == 2'd3);

  assign own   = (a_m1 ? (a_in ? OWN_AI : OWN_AO) : 8'h00) | (b_m1 ? OWN_B : 8'h00);
  assign dir_c = {{4{~cu_in}}, {4{~cl_in}}};
  assign iem   = ((a_m1 && a_in)  ? 8'h10 : 8'h00)
               | ((a_m1 && !a_in) ? 8'h40 : 8'h00)
               | (b_m1 ? 8'h04 : 8'h00);
  assign iev   = {1'b0, ie_ao, 1'b0, ie_ai, 1'b0, ie_b, 2'b00} & iem;
  assign gp_c  = (dir_c & lc) | (~dir_c & pc_in);

  always_comb begin
    case (addr)
      2'd0:    rd_mux = !a_in ? la : (a_m1 ? hold_a : pa_in);
      2'd1:    rd_mux = !b_in ? lb : (b_m1 ? hold_b : pb_in);
      2'd2:    rd_mux = (~own & gp_c) | (own & ~iem & hs_stat) | iev;
      default: rd_mux = {2'b10, a_m1, a_in, cu_in, b_m1, b_in, cl_in};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_m1 <= 1'b0; a_in <= 1'b1; cu_in <= 1'b1;
      b_m1 <= 1'b0; b_in <= 1'b1; cl_in <= 1'b1;
      la <= '0; lb <= '0; lc <= '0;
      hold_a <= '0; hold_b <= '0;
      ie_ai <= 1'b0; ie_ao <= 1'b0; ie_b <= 1'b0;
      rdata <= '0;
    end else begin
      if (a_stb && a_m1 && a_in) hold_a <= pa_in;
      if (b_stb && b_m1 && b_in) hold_b <= pb_in;
      if (cs && rd) rdata <= rd_mux;
      if (cs && wr && addr == 2'd0) la <= wdata;
      if (cs && wr && addr == 2'd1) lb <= wdata;
      if (cs && wr && addr == 2'd2) lc <= wdata;
      if (wr_ctl && wdata[7] && !wdata[6]) begin
        a_m1  <= wdata[5];
        a_in  <= wdata[4];
        cu_in <= wdata[3];
        b_m1  <= wdata[2];
        b_in  <= wdata[1];
        cl_in <= wdata[0];
        la <= '0; lb <= '0; lc <= '0;
        ie_ai <= 1'b0; ie_ao <= 1'b0; ie_b <= 1'b0;
      end
      if (wr_ctl && !wdata[7]) begin
        lc[wdata[3:1]] <= wdata[0];
        if (wdata[3:1] == POS_AI && a_m1 && a_in)  ie_ai <= wdata[0];
        if (wdata[3:1] == POS_AO && a_m1 && !a_in) ie_ao <= wdata[0];
        if (wdata[3:1] == POS_B  && b_m1)          ie_b  <= wdata[0];
      end
    end
  end

  assign pa_out  = la;
  assign pb_out  = lb;
  assign pc_out  = lc;
  assign pa_oe   = {8{~a_in}};
  assign pb_oe   = {8{~b_in}};
  assign pc_oe   = dir_c & ~own;
  assign a_mode1 = a_m1;
  assign a_is_in = a_in;
  assign b_mode1 = b_m1;
  assign b_is_in = b_in;
  assign inte_a  = a_in ? ie_ai : ie_ao;
  assign inte_b  = ie_b;
endmodule

module pio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       wr,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pc_out,
  input logic [7:0] pc_oe,
  input logic       a_mode1,
  input logic       a_is_in,
  input logic       b_mode1,
  input logic       b_is_in,
  input logic       inte_a,
  input logic       inte_b
);
  logic ctl_w;
  assign ctl_w = cs && wr && (addr == 2'd3);

  AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_w |=> ($stable(a_mode1) && $stable(a_is_in) && $stable(b_mode1) && $stable(b_is_in))); // R3

  AST_MODESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && wdata[7] && !wdata[6]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00 && !inte_a && !inte_b)); // R4

  AST_BIDIR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && wdata[7] && wdata[6]) |=> ($stable(a_mode1) && $stable(a_is_in) && $stable(b_mode1) && $stable(b_is_in) && $stable(pa_out) && $stable(pb_out) && $stable(pc_out))); // R5

  AST_BSR_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_w && !wdata[7]) |=> ($countones(pc_out ^ $past(pc_out)) <= 1)); // R6

  AST_CLAIMED_B_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    b_mode1 |-> (pc_oe[2:0] == 3'b000)); // R12

  AST_CLAIMED_A_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    a_mode1 |-> (pc_oe[3] == 1'b0)); // R12

  AST_INTE_B_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    inte_b |-> b_mode1); // R11

  AST_INTE_A_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    inte_a |-> a_mode1); // R11
endmodule

bind pio_ctrl pio_ctrl_chk u_chk (.*);

// File: tb/sim_pio_ctrl.sv
module sim_pio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0, hs_stat = '0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic       a_stb = 1'b0, b_stb = 1'b0;
  logic       a_mode1, a_is_in, b_mode1, b_is_in, inte_a, inte_b;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  pio_ctrl u0 (.*);

  always @(posedge clk) pend <= cs && rd;

  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata=%02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string t);
    n_chk++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", t, act, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pa_oe | pb_oe | pc_oe, 8'h00, "R1 output enables");
    chk({6'd0, inte_a, inte_b}, 8'h00, "R1 interrupt enables");
    chk(pa_out | pb_out | pc_out, 8'h00, "R1 latches");
    rd_reg(2'd3, 8'h9B, "R1 control readback");
    // R8 mode 0 inputs, R2 decode
    pa_in = 8'h5A; pb_in = 8'hC3;
    rd_reg(2'd0, 8'h5A, "R8 port A live pins");
    rd_reg(2'd1, 8'hC3, "R2 port B location");
    // R3 90h
    wr_reg(2'd3, 8'h90);
    @(negedge clk);
    chk({6'd0, a_is_in, b_is_in}, 8'h02, "R3 directions for 90h");
    chk(pb_oe, 8'hFF, "R7 port B enables");
    chk(pc_oe, 8'hFF, "R12 port C enables mode 0 output");
    rd_reg(2'd3, 8'h90, "R3 control readback 90h");
    // R7 outputs
    wr_reg(2'd1, 8'h3C);
    chk(pb_out, 8'h3C, "R7 port B latch out");
    rd_reg(2'd1, 8'h3C, "R7 port B reads latch");
    wr_reg(2'd2, 8'hA5);
    rd_reg(2'd2, 8'hA5, "R7 port C reads latch");
    // R6 bit set/reset
    wr_reg(2'd3, 8'h07);
    chk(pc_out, 8'hAD, "R6 set PC3");
    wr_reg(2'd3, 8'h00);
    chk(pc_out, 8'hAC, "R6 clear PC0");
    rd_reg(2'd3, 8'h90, "R6 configuration untouched");
    // R4 clear on mode set
    wr_reg(2'd3, 8'h90);
    chk(pb_out | pc_out, 8'h00, "R4 latches cleared");
    // R5 bidirectional encoding dropped
    wr_reg(2'd1, 8'h11);
    wr_reg(2'd3, 8'hE0);
    chk(pb_out, 8'h11, "R5 latch kept");
    rd_reg(2'd3, 8'h90, "R5 configuration kept");
    // R2 write without select
    wr_reg(2'd1, 8'h77, 1'b0);
    chk(pb_out, 8'h11, "R2 unselected write");
    // R9 strobed input
    wr_reg(2'd3, 8'hB0);
    chk({7'd0, a_mode1}, 8'h01, "R3 B0h gives A mode 1");
    chk(pc_oe, 8'hC7, "R12 A input claims PC3..PC5");
    pa_in = 8'h11;
    @(negedge clk); a_stb = 1'b1;
    @(negedge clk); a_stb = 1'b0;
    pa_in = 8'h99;
    rd_reg(2'd0, 8'h11, "R9 captured byte");
    // R10, R11 status word
    hs_stat = 8'h20;
    wr_reg(2'd3, 8'h09);
    chk({7'd0, inte_a}, 8'h01, "R11 PC4 sets A enable");
    rd_reg(2'd2, 8'h30, "R10 status word");
    // B mode 1 output
    wr_reg(2'd3, 8'hB4);
    chk({6'd0, inte_a, inte_b}, 8'h00, "R4 enables cleared");
    wr_reg(2'd3, 8'h05);
    chk({7'd0, inte_b}, 8'h01, "R11 PC2 sets B enable");
    chk(pc_oe, 8'hC0, "R12 A and B claim lines");
    // A mode 1 output
    wr_reg(2'd3, 8'hA0);
    wr_reg(2'd3, 8'h09);
    chk({7'd0, inte_a}, 8'h00, "R11 PC4 ignored in A output");
    wr_reg(2'd3, 8'h0D);
    chk({7'd0, inte_a}, 8'h01, "R11 PC6 sets A output enable");
    wr_reg(2'd0, 8'h5E);
    chk(pa_oe, 8'hFF, "R7 port A enables mode 1");
    rd_reg(2'd0, 8'h5E, "R7 mode 1 output reads latch");
    // split port C halves
    wr_reg(2'd3, 8'h88);
    pc_in = 8'hA0;
    wr_reg(2'd2, 8'h3C);
    chk(pc_oe, 8'h0F, "R12 upper half input");
    rd_reg(2'd2, 8'hAC, "R8 port C mixed halves");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule